// File: doc/BRIEF.md
# Host Command Handshake and Interrupt Acknowledge Controller

This block holds the host-facing control registers of a network controller. The host writes one command byte carrying a command-unit opcode and a receive-unit opcode, and it can load a general pointer. The command is not taken when it is written. The block waits until the device reports itself free of higher-priority work, such as buffer prefetch, buffer switching or finishing a frame. It then runs a fixed acceptance sequence:

1. Latch the command byte.
2. Latch the pointer.
3. Issue a one-cycle request to the receive unit.
4. Issue a one-cycle request to the command unit.
5. Clear the command byte and load the status from the two units' internal states.

The host learns that a command was taken when the command byte reads zero again. Only then may it write the next one.

The block also keeps a vector of pending interrupt bits. New events set bits. A host acknowledge write clears every bit written as one. The active-low interrupt line stays asserted while any bit is pending.

Top module: `cmd_irq_hs`

## Requirements
- R1: After reset the outputs are as follows: `cmd_byte` is 0, `irq_pend` is 0, `irq_n` is 1, `ru_req`, `cu_req` and `proto_err` are 0, and both status outputs are 0.
- R2: The command byte holds the command-unit opcode in bits 7:4 and the receive-unit opcode in bits 2:0. Bit 3 selects nothing. An opcode of zero means no command for that unit.
- R3: While `dev_busy` is high and the block is idle, a pending nonzero command byte is not accepted: no request is issued and the byte keeps its value. The sequence starts on the first clock edge at which `dev_busy` is low. Once started, the sequence does not pause for `dev_busy`.
- R4: `ru_req` is a one-cycle pulse in the third cycle after the edge that starts the sequence. During that pulse `ru_cmd` carries bits 2:0 of the accepted byte and `req_ptr` carries the latched pointer. If the receive-unit opcode is zero, there is no pulse.
- R5: `cu_req` is a one-cycle pulse in the cycle directly after the receive-unit slot, with `cu_cmd` carrying bits 7:4. If the command-unit opcode is zero, there is no pulse. The receive unit is always served before the command unit.
- R6: The pointer presented on `req_ptr` is the value last written by `ptr_wr` before the sequence latched it.
- R7: At the clock edge ending the command-unit slot, two things happen. `cmd_byte` becomes 0, and `stat_cu`/`stat_ru` load `cu_state`/`ru_state`. The status outputs change at no other time.
- R8: A command write while `cmd_byte` is nonzero is dropped.
- R9: A taken write with both opcode fields nonzero raises `proto_err` for exactly the next cycle. The command is still processed, receive unit first.
- R10: A high bit of `irq_evt` sets the matching `irq_pend` bit on the next edge. An `ack_wr` clears every `irq_pend` bit that is one in `ack_wdata` on the next edge, and several bits can be cleared in one write.
- R11: If an event and an acknowledge for the same bit arrive in the same cycle, the bit stays set.
- R12: `irq_n` is 0 exactly when at least one `irq_pend` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host command byte write strobe |
| cmd_wdata | input | 8 | Command byte written by the host |
| ptr_wr | input | 1 | Host pointer write strobe |
| ptr_wdata | input | PTR_W | Pointer written by the host |
| ack_wr | input | 1 | Host interrupt acknowledge write strobe |
| ack_wdata | input | NIRQ | Bits to clear, one per pending interrupt |
| dev_busy | input | 1 | Device engaged in higher-priority work |
| irq_evt | input | NIRQ | Interrupt event pulses |
| cu_state | input | CUS_W | Internal command-unit state |
| ru_state | input | RUS_W | Internal receive-unit state |
| cmd_byte | output | 8 | Command byte as the host reads it |
| ru_req | output | 1 | Receive-unit command request pulse |
| ru_cmd | output | 3 | Receive-unit opcode |
| cu_req | output | 1 | Command-unit command request pulse |
| cu_cmd | output | 4 | Command-unit opcode |
| req_ptr | output | PTR_W | Pointer latched by the sequence |
| stat_cu | output | CUS_W | Command-unit status |
| stat_ru | output | RUS_W | Receive-unit status |
| irq_pend | output | NIRQ | Pending interrupt bits |
| irq_n | output | 1 | Active-low interrupt line |
| proto_err | output | 1 | Both opcode fields nonzero in one write |

## Verification
A sequencer stuck in a wrong state shows within five cycles of a write. Either `cmd_byte` never returns to zero, or a request pulse lands in the wrong cycle or is doubled. A wrong opcode latch shows as a wrong value on `ru_cmd`/`cu_cmd` during the pulse, which exposes a second write slipping in before the latch. A wrong interrupt vector shows one cycle after an event or acknowledge, both on `irq_pend` and on `irq_n`.

// File: rtl/cmd_irq_hs.sv
module cmd_irq_hs #(
  parameter int NIRQ  = 6,
  parameter int PTR_W = 32,
  parameter int CUS_W = 2,
  parameter int RUS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_wdata,
  input  logic             ptr_wr,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             ack_wr,
  input  logic [NIRQ-1:0]  ack_wdata,
  input  logic             dev_busy,
  input  logic [NIRQ-1:0]  irq_evt,
  input  logic [CUS_W-1:0] cu_state,
  input  logic [RUS_W-1:0] ru_state,
  output logic [7:0]       cmd_byte,
  output logic             ru_req,
  output logic [2:0]       ru_cmd,
  output logic             cu_req,
  output logic [3:0]       cu_cmd,
  output logic [PTR_W-1:0] req_ptr,
  output logic [CUS_W-1:0] stat_cu,
  output logic [RUS_W-1:0] stat_ru,
  output logic [NIRQ-1:0]  irq_pend,
  output logic             irq_n,
  output logic             proto_err
);
  typedef enum logic [2:0] {S_IDLE, S_RDCMD, S_RDPTR, S_RU, S_CU} st_t;

  st_t              st;
  logic [7:0]       cmd_lat;
  logic [PTR_W-1:0] ptr_reg, ptr_lat;
  logic             wr_take;

  assign wr_take = cmd_wr && (cmd_byte == 8'h00);
  assign ru_cmd  = cmd_lat[2:0];
  assign cu_cmd  = cmd_lat[7:4];
  assign ru_req  = (st == S_RU) && (ru_cmd != 3'd0);
  assign cu_req  = (st == S_CU) && (cu_cmd != 4'd0);
  assign req_ptr = ptr_lat;
  assign irq_n   = ~|irq_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cmd_byte  <= '0;
      cmd_lat   <= '0;
      ptr_reg   <= '0;
      ptr_lat   <= '0;
      stat_cu   <= '0;
      stat_ru   <= '0;
      irq_pend  <= '0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= wr_take && (cmd_wdata[7:4] != 4'd0) && (cmd_wdata[2:0] != 3'd0);
      if (st == S_CU)   cmd_byte <= '0;
      else if (wr_take) cmd_byte <= cmd_wdata;
      if (ptr_wr) ptr_reg <= ptr_wdata;
      irq_pend <= (irq_pend & ~(ack_wr ? ack_wdata : '0)) | irq_evt;
      case (st)
        S_IDLE:  if (cmd_byte != 8'h00 && !dev_busy) st <= S_RDCMD;
        S_RDCMD: begin cmd_lat <= cmd_byte; st <= S_RDPTR; end
        S_RDPTR: begin ptr_lat <= ptr_reg;  st <= S_RU;    end
        S_RU:    st <= S_CU;
        S_CU: begin
          stat_cu <= cu_state;
          stat_ru <= ru_state;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cmd_irq_hs_chk #(
  parameter int NIRQ  = 6,
  parameter int CUS_W = 2,
  parameter int RUS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       st,
  input logic             cmd_wr,
  input logic             dev_busy,
  input logic [7:0]       cmd_byte,
  input logic             ru_req,
  input logic             cu_req,
  input logic             ack_wr,
  input logic [NIRQ-1:0]  ack_wdata,
  input logic [NIRQ-1:0]  irq_evt,
  input logic [NIRQ-1:0]  irq_pend,
  input logic [CUS_W-1:0] stat_cu,
  input logic [RUS_W-1:0] stat_ru
);
  localparam logic [2:0] IDLE = 3'd0;
  localparam logic [2:0] CU   = 3'd4;

  p_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && dev_busy) |=> (st == IDLE));
  p_ru_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ru_req |=> !ru_req);
  p_ru_then_cu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ru_req |=> (st == CU));
  p_clear_after_cu_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cu_req |=> (cmd_byte == 8'h00));
  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != CU) |=> ($stable(stat_cu) && $stable(stat_ru)));
  p_drop_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_byte != 8'h00 && st != CU) |=> $stable(cmd_byte));
  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((irq_pend & $past(ack_wdata & ~irq_evt)) == '0));
  p_evt_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_evt) |=> ((irq_pend & $past(irq_evt)) == $past(irq_evt)));
endmodule

bind cmd_irq_hs cmd_irq_hs_chk #(.NIRQ(NIRQ), .CUS_W(CUS_W), .RUS_W(RUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .cmd_wr(cmd_wr), .dev_busy(dev_busy),
  .cmd_byte(cmd_byte), .ru_req(ru_req), .cu_req(cu_req), .ack_wr(ack_wr),
  .ack_wdata(ack_wdata), .irq_evt(irq_evt), .irq_pend(irq_pend),
  .stat_cu(stat_cu), .stat_ru(stat_ru));

// File: tb/test_cmd_irq_hs.sv
module test_cmd_irq_hs;
  localparam int NIRQ = 6, PTR_W = 32, CUS_W = 2, RUS_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, ptr_wr = 0, ack_wr = 0, dev_busy = 0;
  logic [7:0] cmd_wdata = '0;
  logic [PTR_W-1:0] ptr_wdata = '0;
  logic [NIRQ-1:0] ack_wdata = '0, irq_evt = '0;
  logic [CUS_W-1:0] cu_state = '0;
  logic [RUS_W-1:0] ru_state = '0;
  logic [7:0] cmd_byte;
  logic ru_req, cu_req, irq_n, proto_err;
  logic [2:0] ru_cmd;
  logic [3:0] cu_cmd;
  logic [PTR_W-1:0] req_ptr;
  logic [CUS_W-1:0] stat_cu;
  logic [RUS_W-1:0] stat_ru;
  logic [NIRQ-1:0] irq_pend;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmd_irq_hs #(.NIRQ(NIRQ), .PTR_W(PTR_W), .CUS_W(CUS_W), .RUS_W(RUS_W)) i_cmd_irq_hs (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] v);
    cmd_wr = 1; cmd_wdata = v;
    @(negedge clk);
    cmd_wr = 0;
  endtask

  // Checks a sequence whose start edge lies just after the current negedge (k=0).
  task automatic follow(logic [7:0] v, logic [PTR_W-1:0] p, int k0);
    logic ru_en, cu_en;
    ru_en = (v[2:0] != 0);
    cu_en = (v[7:4] != 0);
    for (int k = k0 + 1; k <= 5; k++) begin
      @(negedge clk);
      check("R4 ru_req slot", ru_req, (k == 3) && ru_en);
      check("R5 cu_req slot", cu_req, (k == 4) && cu_en);
      if (k == 3 && ru_en) begin
        check("R4 ru_cmd", ru_cmd, v[2:0]);
        check("R6 req_ptr", req_ptr, p);
      end
      if (k == 4 && cu_en) check("R5 cu_cmd", cu_cmd, v[7:4]);
      if (k == 4) check("R7 byte held", cmd_byte, v);
      if (k == 5) begin
        check("R7 byte cleared", cmd_byte, 0);
        check("R7 stat_cu", stat_cu, cu_state);
        check("R7 stat_ru", stat_ru, ru_state);
      end
    end
  endtask

  // {command byte, expected proto_err}
  localparam logic [8:0] VEC [7] = '{
    {8'h10, 1'b0}, {8'h04, 1'b0}, {8'h08, 1'b0}, {8'hF7, 1'b1},
    {8'h03, 1'b0}, {8'hA0, 1'b0}, {8'h91, 1'b1}};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cmd_byte", cmd_byte, 0);
    check("R1 irq_pend", irq_pend, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 reqs", {ru_req, cu_req, proto_err}, 0);
    check("R1 status", {stat_cu, stat_ru}, 0);

    // R2 R4 R5 R6 R7 R9 table walk
    for (int i = 0; i < 7; i++) begin
      logic [7:0] v;
      v = VEC[i][8:1];
      ptr_wr = 1; ptr_wdata = 32'hC0DE_0000 + i;
      cu_state = CUS_W'(i + 1); ru_state = RUS_W'(i + 9);
      @(negedge clk);
      ptr_wr = 0;
      do_write(v);
      check("R9 proto_err", proto_err, VEC[i][0]);
      follow(v, 32'hC0DE_0000 + i, 0);
      @(negedge clk);
      check("R9 proto_err one cycle", proto_err, 0);
    end

    // R3 deferral while busy
    dev_busy = 1; cu_state = 2'd2; ru_state = 4'd3;
    do_write(8'h15);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R3 no req while busy", {ru_req, cu_req}, 0);
      check("R3 byte kept while busy", cmd_byte, 8'h15);
    end
    check("R3 status unchanged while busy", stat_ru, 4'd15);
    dev_busy = 0;
    follow(8'h15, 32'hC0DE_0006, 0);

    // R3 busy rising mid-sequence does not stall
    do_write(8'h06);
    @(negedge clk);
    dev_busy = 1;
    follow(8'h06, 32'hC0DE_0006, 1);
    dev_busy = 0;

    // R8 second write while byte nonzero is dropped
    do_write(8'h02);
    do_write(8'h30);
    follow(8'h02, 32'hC0DE_0006, 1);
    @(negedge clk);
    check("R8 no late command", cmd_byte, 0);

    // R10 R11 R12 interrupts
    irq_evt = 6'b000111;
    @(negedge clk); irq_evt = '0;
    check("R10 set", irq_pend, 6'b000111);
    check("R12 irq_n low", irq_n, 0);
    ack_wr = 1; ack_wdata = 6'b000011;
    @(negedge clk); ack_wr = 0;
    check("R10 ack multi-bit", irq_pend, 6'b000100);
    check("R12 irq_n still low", irq_n, 0);
    irq_evt = 6'b000100; ack_wr = 1; ack_wdata = 6'b000100;
    @(negedge clk); irq_evt = '0; ack_wr = 0;
    check("R11 event wins", irq_pend, 6'b000100);
    ack_wr = 1; ack_wdata = 6'b000100;
    @(negedge clk); ack_wr = 0;
    check("R10 cleared", irq_pend, 0);
    check("R12 irq_n high", irq_n, 1);
    irq_evt = 6'b111000;
    @(negedge clk); irq_evt = '0;
    ack_wr = 1; ack_wdata = 6'b111111;
    @(negedge clk); ack_wr = 0;
    check("R10 ack all", irq_pend, 0);
    check("R12 irq_n after ack all", irq_n, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule